// File: doc/BRIEF.md
# Debug Command Sequencer

This block sits between a host command link and an experiment circuit under test. It takes one decoded command message at a time from the link and acts on the experiment: it reads or writes the experiment's memory bus, pulses the experiment's reset, and controls its clock enable. It answers every recognised command with one response message. A mode flag selects between manual operation, where the host steps the experiment one cycle at a time and may access its memory, and autonomous operation, where the experiment runs freely. A command that is not legal in the current mode is answered with a dedicated error code and has no effect.

A cycle counter records how many clock edges have passed with the experiment clock enabled since system reset or the last reset command. Start, pause, step and status responses carry this count. Input messages are accepted with a combinational rx_ready/rx_next handshake. Responses leave through a registered tx_next strobe with tx_msg. A command is only taken when the response side can accept a response, so no response is dropped.

Top module: `dbg_cmd_seq`

## Requirements
- R1: While rst_n is low, rx_next, exp_wen and tx_next are low and exp_rst is at level EXP_RST_LEVEL. After reset the block is in manual mode, exp_clk_en is low and the cycle count is 0.
- R2: A message is {opcode[3:0], address[ADDR_W-1:0], data[DATA_W-1:0]}, with the opcode in the top bits. Command codes are read=0, write=1, reset=2, step=3, start=4, pause=5 and status=6. rx_next equals rx_ready AND tx_ready, combinationally. Opcodes 7 to 15 are consumed with no response and no effect.
- R3: Each accepted command with a known code gives exactly one response. tx_next is high for the one cycle after the accepting edge, and tx_msg = {response code, payload} holds from then until the next response. Response codes are read-ok=0, read-err=1, write-ok=2, write-err=3, reset-ok=4, step-ok=5, step-err=6, start-ok=7, start-err=8, pause-ok=9, pause-err=10 and status=11.
- R4: A read in manual mode answers read-ok with payload {address, exp_rdata}, where exp_rdata is sampled at the accepting edge. exp_addr always shows the message's address field.
- R5: A write in manual mode raises exp_wen combinationally while it is presented and accepted, with exp_addr and exp_wdata equal to the message fields. It answers write-ok with payload {address, data}.
- R6: A reset command drives exp_rst to EXP_RST_LEVEL combinationally while it is accepted, clears the cycle count and leaves the mode unchanged. It answers reset-ok with payload 0.
- R7: A step in manual mode raises exp_clk_en for exactly the one cycle after the accepting edge. It answers step-ok with the count after that stepped cycle.
- R8: Start in manual mode enters autonomous mode and answers start-ok with the count just after the accepting edge. In autonomous mode exp_clk_en is high every cycle and the count advances by one per edge. Pause in autonomous mode returns to manual, which freezes the count, and answers pause-ok with the frozen count.
- R9: In autonomous mode, read and write answer read-err or write-err with payload {address, 0}, step answers step-err with payload 0, and start answers start-err with payload 0. In manual mode, pause answers pause-err with payload 0. A rejected command raises no exp_wen, adds no enabled cycle and does not change the mode.
- R10: Status answers status with the count just after the accepting edge and changes no state.
- R11: While tx_ready is low no command is consumed. rx_next, exp_wen and the reset pulse stay inactive and no response is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rx_msg | input | 4+ADDR_W+DATA_W | Command message from the link |
| rx_ready | input | 1 | rx_msg holds a valid command |
| rx_next | output | 1 | Command consumed at the next edge |
| tx_ready | input | 1 | Response side can take a response |
| tx_next | output | 1 | tx_msg holds a new response this cycle |
| tx_msg | output | 4+ADDR_W+DATA_W | Response message |
| exp_addr | output | ADDR_W | Experiment memory address |
| exp_wdata | output | DATA_W | Experiment write data |
| exp_rdata | input | DATA_W | Experiment read data |
| exp_wen | output | 1 | Experiment write enable |
| exp_rst | output | 1 | Experiment reset, active level EXP_RST_LEVEL |
| exp_clk_en | output | 1 | Experiment clock enable |

## Verification
A wrong mode flag shows in the cycle after the faulty edge. A stuck autonomous flag holds exp_clk_en high and turns the next read, write or step into an error code. A lost one leaves exp_clk_en low during a status check. A cycle counter that skips or double-counts shows up in the payload of the next start, pause, step or status response, so the command table places status reads right after each mode change. A step pulse held too long or too briefly is caught by sampling exp_clk_en in both the response cycle and the idle cycle after it.

// File: rtl/dbg_seq_pkg.sv
`timescale 1ns/1ps
package dbg_seq_pkg;

    localparam int OPC_W = 4;

    // command codes
    localparam logic [OPC_W-1:0] CMD_READ   = 4'd0;
    localparam logic [OPC_W-1:0] CMD_WRITE  = 4'd1;
    localparam logic [OPC_W-1:0] CMD_RESET  = 4'd2;
    localparam logic [OPC_W-1:0] CMD_STEP   = 4'd3;
    localparam logic [OPC_W-1:0] CMD_START  = 4'd4;
    localparam logic [OPC_W-1:0] CMD_PAUSE  = 4'd5;
    localparam logic [OPC_W-1:0] CMD_STATUS = 4'd6;

    // response codes
    localparam logic [OPC_W-1:0] RSP_RD_OK     = 4'd0;
    localparam logic [OPC_W-1:0] RSP_RD_ERR    = 4'd1;
    localparam logic [OPC_W-1:0] RSP_WR_OK     = 4'd2;
    localparam logic [OPC_W-1:0] RSP_WR_ERR    = 4'd3;
    localparam logic [OPC_W-1:0] RSP_RST_OK    = 4'd4;
    localparam logic [OPC_W-1:0] RSP_STEP_OK   = 4'd5;
    localparam logic [OPC_W-1:0] RSP_STEP_ERR  = 4'd6;
    localparam logic [OPC_W-1:0] RSP_START_OK  = 4'd7;
    localparam logic [OPC_W-1:0] RSP_START_ERR = 4'd8;
    localparam logic [OPC_W-1:0] RSP_PAUSE_OK  = 4'd9;
    localparam logic [OPC_W-1:0] RSP_PAUSE_ERR = 4'd10;
    localparam logic [OPC_W-1:0] RSP_STATUS    = 4'd11;

    // payload source chosen by the decoder, built by the response stage
    typedef enum logic [2:0] {
        PAY_ZERO,
        PAY_ADDR_ZERO,
        PAY_ADDR_RDATA,
        PAY_ADDR_WDATA,
        PAY_COUNT,
        PAY_COUNT_INC
    } pay_sel_e;

    typedef struct packed {
        logic             accept;
        logic             wr_go;
        logic             rst_go;
        logic             step_go;
        logic             start_go;
        logic             pause_go;
        logic             rsp_valid;
        logic [OPC_W-1:0] rsp_opc;
        pay_sel_e         pay;
    } dec_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
`timescale 1ns/1ps
module dbg_cmd_decode
    import dbg_seq_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 8,
    localparam int VAL_W  = ADDR_W + DATA_W,
    localparam int MSG_W  = OPC_W + VAL_W
) (
    input  logic              rst_ni,
    input  logic [MSG_W-1:0]  rx_msg_i,
    input  logic              rx_ready_i,
    input  logic              tx_ready_i,
    input  logic              auto_i,
    output dec_t              dec_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    logic [OPC_W-1:0] opc;

    assign opc    = rx_msg_i[MSG_W-1 -: OPC_W];
    assign addr_o = rx_msg_i[VAL_W-1:DATA_W];
    assign data_o = rx_msg_i[DATA_W-1:0];

    always_comb begin
        dec_o        = '0;
        dec_o.pay    = PAY_ZERO;
        // taken only when a response can be handed on
        dec_o.accept = rst_ni & rx_ready_i & tx_ready_i;
        if (dec_o.accept) begin
            case (opc)
                CMD_READ: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.rsp_opc   = auto_i ? RSP_RD_ERR : RSP_RD_OK;
                    dec_o.pay       = auto_i ? PAY_ADDR_ZERO : PAY_ADDR_RDATA;
                end
                CMD_WRITE: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.wr_go     = ~auto_i;
                    dec_o.rsp_opc   = auto_i ? RSP_WR_ERR : RSP_WR_OK;
                    dec_o.pay       = auto_i ? PAY_ADDR_ZERO : PAY_ADDR_WDATA;
                end
                CMD_RESET: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.rst_go    = 1'b1;
                    dec_o.rsp_opc   = RSP_RST_OK;
                    dec_o.pay       = PAY_ZERO;
                end
                CMD_STEP: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.step_go   = ~auto_i;
                    dec_o.rsp_opc   = auto_i ? RSP_STEP_ERR : RSP_STEP_OK;
                    dec_o.pay       = auto_i ? PAY_ZERO : PAY_COUNT_INC;
                end
                CMD_START: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.start_go  = ~auto_i;
                    dec_o.rsp_opc   = auto_i ? RSP_START_ERR : RSP_START_OK;
                    dec_o.pay       = auto_i ? PAY_ZERO : PAY_COUNT;
                end
                CMD_PAUSE: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.pause_go  = auto_i;
                    dec_o.rsp_opc   = auto_i ? RSP_PAUSE_OK : RSP_PAUSE_ERR;
                    dec_o.pay       = auto_i ? PAY_COUNT : PAY_ZERO;
                end
                CMD_STATUS: begin
                    dec_o.rsp_valid = 1'b1;
                    dec_o.rsp_opc   = RSP_STATUS;
                    dec_o.pay       = PAY_COUNT;
                end
                default: begin
                    // unknown code: consumed, nothing else happens
                    dec_o.rsp_valid = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dbg_cycle_ctrl.sv
`timescale 1ns/1ps
module dbg_cycle_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_go_i,
    input  logic             start_go_i,
    input  logic             pause_go_i,
    input  logic             clear_i,
    output logic             clk_en_o,
    output logic             auto_o,
    output logic [CNT_W-1:0] cnt_now_o
);

    typedef struct packed {
        logic             auto_m;
        logic             step;
        logic [CNT_W-1:0] cnt;
    } cyc_t;

    cyc_t st_d, st_q;

    assign clk_en_o = st_q.auto_m | st_q.step;
    assign auto_o   = st_q.auto_m;
    // count as it stands once the current edge has passed
    assign cnt_now_o = st_q.cnt + CNT_W'(clk_en_o);

    always_comb begin
        st_d = st_q;
        if (start_go_i) begin
            st_d.auto_m = 1'b1;
        end else if (pause_go_i) begin
            st_d.auto_m = 1'b0;
        end
        st_d.step = step_go_i;
        st_d.cnt  = clear_i ? '0 : cnt_now_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dbg_resp_build.sv
`timescale 1ns/1ps
module dbg_resp_build
    import dbg_seq_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 8,
    localparam int VAL_W  = ADDR_W + DATA_W,
    localparam int MSG_W  = OPC_W + VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid_i,
    input  logic [OPC_W-1:0]  rsp_opc_i,
    input  pay_sel_e          pay_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [VAL_W-1:0]  cnt_i,
    output logic              tx_next_o,
    output logic [MSG_W-1:0]  tx_msg_o
);

    typedef struct packed {
        logic             vld;
        logic [MSG_W-1:0] msg;
    } rsp_t;

    rsp_t             st_d, st_q;
    logic [VAL_W-1:0] pay_v;

    always_comb begin
        case (pay_i)
            PAY_ADDR_ZERO:  pay_v = {addr_i, {DATA_W{1'b0}}};
            PAY_ADDR_RDATA: pay_v = {addr_i, rdata_i};
            PAY_ADDR_WDATA: pay_v = {addr_i, wdata_i};
            PAY_COUNT:      pay_v = cnt_i;
            PAY_COUNT_INC:  pay_v = cnt_i + VAL_W'(1);
            default:        pay_v = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = rsp_valid_i;
        if (rsp_valid_i) begin
            st_d.msg = {rsp_opc_i, pay_v};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_next_o = st_q.vld;
    assign tx_msg_o  = st_q.msg;

endmodule

// File: rtl/dbg_cmd_seq.sv
`timescale 1ns/1ps
module dbg_cmd_seq
    import dbg_seq_pkg::*;
#(
    parameter  int   ADDR_W        = 8,
    parameter  int   DATA_W        = 8,
    parameter  logic EXP_RST_LEVEL = 1'b1,
    localparam int   VAL_W         = ADDR_W + DATA_W,
    localparam int   MSG_W         = OPC_W + VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MSG_W-1:0]  rx_msg,
    input  logic              rx_ready,
    output logic              rx_next,
    input  logic              tx_ready,
    output logic              tx_next,
    output logic [MSG_W-1:0]  tx_msg,
    output logic [ADDR_W-1:0] exp_addr,
    output logic [DATA_W-1:0] exp_wdata,
    input  logic [DATA_W-1:0] exp_rdata,
    output logic              exp_wen,
    output logic              exp_rst,
    output logic              exp_clk_en
);

    dec_t              dec;
    logic              auto_mode;
    logic [VAL_W-1:0]  cnt_now;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;

    dbg_cmd_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .rst_ni     (rst_n),
        .rx_msg_i   (rx_msg),
        .rx_ready_i (rx_ready),
        .tx_ready_i (tx_ready),
        .auto_i     (auto_mode),
        .dec_o      (dec),
        .addr_o     (f_addr),
        .data_o     (f_data)
    );

    dbg_cycle_ctrl #(
        .CNT_W (VAL_W)
    ) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_go_i  (dec.step_go),
        .start_go_i (dec.start_go),
        .pause_go_i (dec.pause_go),
        .clear_i    (dec.rst_go),
        .clk_en_o   (exp_clk_en),
        .auto_o     (auto_mode),
        .cnt_now_o  (cnt_now)
    );

    dbg_resp_build #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rsp_valid_i (dec.rsp_valid),
        .rsp_opc_i   (dec.rsp_opc),
        .pay_i       (dec.pay),
        .addr_i      (f_addr),
        .wdata_i     (f_data),
        .rdata_i     (exp_rdata),
        .cnt_i       (cnt_now),
        .tx_next_o   (tx_next),
        .tx_msg_o    (tx_msg)
    );

    assign rx_next   = dec.accept;
    assign exp_addr  = f_addr;
    assign exp_wdata = f_data;
    assign exp_wen   = dec.wr_go;
    assign exp_rst   = (!rst_n || dec.rst_go) ? EXP_RST_LEVEL : ~EXP_RST_LEVEL;

endmodule

// File: rtl/dbg_cmd_seq_chk.sv
`timescale 1ns/1ps
module dbg_cmd_seq_chk #(
    parameter int   MSG_W         = 20,
    parameter logic EXP_RST_LEVEL = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MSG_W-1:0] rx_msg,
    input logic             rx_ready,
    input logic             tx_ready,
    input logic             rx_next,
    input logic             tx_next,
    input logic             exp_wen,
    input logic             exp_rst,
    input logic             exp_clk_en,
    input logic             auto_mode
);

    logic [3:0] opc;
    assign opc = rx_msg[MSG_W-1 -: 4];

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (exp_rst == EXP_RST_LEVEL && !rx_next && !exp_wen)
                else $error("R1 outputs not quiet during reset");
        end
    end

    assert_take_needs_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> (!rx_next && !exp_wen));

    assert_take_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_next |-> rx_ready);

    assert_resp_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_next |-> $past(rx_next));

    assert_wen_manual_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exp_wen |-> !auto_mode);

    assert_auto_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode |-> exp_clk_en);

    assert_step_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_clk_en && !auto_mode) |-> $past(rx_next && opc == 4'd3));

    assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_next && opc == 4'd2) |-> exp_rst == EXP_RST_LEVEL);

endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk #(
    .MSG_W         (MSG_W),
    .EXP_RST_LEVEL (EXP_RST_LEVEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_msg     (rx_msg),
    .rx_ready   (rx_ready),
    .tx_ready   (tx_ready),
    .rx_next    (rx_next),
    .tx_next    (tx_next),
    .exp_wen    (exp_wen),
    .exp_rst    (exp_rst),
    .exp_clk_en (exp_clk_en),
    .auto_mode  (auto_mode)
);

// File: tb/dbg_cmd_seq_tb.sv
`timescale 1ns/1ps
module dbg_cmd_seq_tb;

    logic        clk;
    logic        rst_n;
    logic [19:0] rx_msg;
    logic        rx_ready;
    logic        rx_next;
    logic        tx_ready;
    logic        tx_next;
    logic [19:0] tx_msg;
    logic [7:0]  exp_addr;
    logic [7:0]  exp_wdata;
    logic [7:0]  exp_rdata;
    logic        exp_wen;
    logic        exp_rst;
    logic        exp_clk_en;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    dbg_cmd_seq #(
        .ADDR_W        (8),
        .DATA_W        (8),
        .EXP_RST_LEVEL (1'b1)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_msg     (rx_msg),
        .rx_ready   (rx_ready),
        .rx_next    (rx_next),
        .tx_ready   (tx_ready),
        .tx_next    (tx_next),
        .tx_msg     (tx_msg),
        .exp_addr   (exp_addr),
        .exp_wdata  (exp_wdata),
        .exp_rdata  (exp_rdata),
        .exp_wen    (exp_wen),
        .exp_rst    (exp_rst),
        .exp_clk_en (exp_clk_en)
    );

    // experiment memory model: data is a fixed function of the address
    assign exp_rdata = exp_addr ^ 8'h5A;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct packed {
        logic [3:0]  opc;
        logic [7:0]  addr;
        logic [7:0]  data;
        logic        wen;
        logic        rst;
        logic        rsp;
        logic [3:0]  res;
        logic [15:0] pay;
        logic        en1;
        logic        en2;
    } vec_t;

    // opc addr data wen rst rsp res pay en1 en2
    localparam vec_t VECS [0:17] = '{
        '{4'h6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd11, 16'd0,     1'b0, 1'b0},
        '{4'h1, 8'h3C, 8'hA5, 1'b1, 1'b0, 1'b1, 4'd2,  16'h3CA5,  1'b0, 1'b0},
        '{4'h0, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b1, 4'd0,  16'h3C66,  1'b0, 1'b0},
        '{4'h3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd5,  16'd1,     1'b1, 1'b0},
        '{4'h3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd5,  16'd2,     1'b1, 1'b0},
        '{4'h6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd11, 16'd2,     1'b0, 1'b0},
        '{4'h5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd10, 16'd0,     1'b0, 1'b0},
        '{4'h4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd7,  16'd2,     1'b1, 1'b1},
        '{4'h6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd11, 16'd4,     1'b1, 1'b1},
        '{4'h0, 8'h11, 8'h00, 1'b0, 1'b0, 1'b1, 4'd1,  16'h1100,  1'b1, 1'b1},
        '{4'h1, 8'h22, 8'h77, 1'b0, 1'b0, 1'b1, 4'd3,  16'h2200,  1'b1, 1'b1},
        '{4'h3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd6,  16'd0,     1'b1, 1'b1},
        '{4'h4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd8,  16'd0,     1'b1, 1'b1},
        '{4'h5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd9,  16'd14,    1'b0, 1'b0},
        '{4'h6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd11, 16'd14,    1'b0, 1'b0},
        '{4'h2, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 4'd4,  16'd0,     1'b0, 1'b0},
        '{4'h6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'd11, 16'd0,     1'b0, 1'b0},
        '{4'hF, 8'hAB, 8'hCD, 1'b0, 1'b0, 1'b0, 4'd0,  16'd0,     1'b0, 1'b0}
    };

    function automatic string tag_of(input logic rsp, input logic [3:0] res);
        if (!rsp) return "R2";
        case (res)
            4'd0:                    return "R4";
            4'd2:                    return "R5";
            4'd4:                    return "R6";
            4'd5:                    return "R7";
            4'd7, 4'd9:              return "R8";
            4'd11:                   return "R10";
            default:                 return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // present a command at a falling edge, withdraw it at the next one
    task automatic send(input logic [3:0] opc, input logic [7:0] a, input logic [7:0] d);
        rx_msg   = {opc, a, d};
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    initial begin
        rst_n    = 1'b0;
        tx_ready = 1'b1;
        rx_ready = 1'b1;
        rx_msg   = {4'h1, 8'h44, 8'h55};
        repeat (3) @(negedge clk);
        // R1: quiet while in system reset, even with a command offered
        check("R1", "rx_next in reset", 32'(rx_next), 32'd0);
        check("R1", "exp_wen in reset", 32'(exp_wen), 32'd0);
        check("R1", "tx_next in reset", 32'(tx_next), 32'd0);
        check("R1", "exp_clk_en in reset", 32'(exp_clk_en), 32'd0);
        check("R1", "exp_rst in reset", 32'(exp_rst), 32'd1);
        rx_ready = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R1", "exp_rst released", 32'(exp_rst), 32'd0);
        check("R1", "exp_clk_en after reset", 32'(exp_clk_en), 32'd0);

        // table walk: each vector takes one accepting edge and one idle edge
        for (int i = 0; i < 18; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = tag_of(v.rsp, v.res);
            rx_msg   = {v.opc, v.addr, v.data};
            rx_ready = 1'b1;
            #1;
            check("R2", $sformatf("rx_next v%0d", i), 32'(rx_next), 32'd1);
            check(v.wen ? "R5" : "R9", $sformatf("exp_wen v%0d", i), 32'(exp_wen), 32'(v.wen));
            check("R6", $sformatf("exp_rst v%0d", i), 32'(exp_rst), 32'(v.rst));
            if (v.opc == 4'h1 && v.wen) begin
                check("R5", "exp_addr on write", 32'(exp_addr), 32'(v.addr));
                check("R5", "exp_wdata on write", 32'(exp_wdata), 32'(v.data));
            end
            @(negedge clk);
            rx_ready = 1'b0;
            check("R3", $sformatf("tx_next v%0d", i), 32'(tx_next), 32'(v.rsp));
            if (v.rsp) begin
                check(t, $sformatf("tx_msg v%0d", i), 32'(tx_msg), 32'({v.res, v.pay}));
            end
            check(v.en1 && !v.en2 ? "R7" : "R8", $sformatf("clk_en after accept v%0d", i),
                  32'(exp_clk_en), 32'(v.en1));
            @(negedge clk);
            check("R3", $sformatf("tx_next idle v%0d", i), 32'(tx_next), 32'd0);
            check(v.en1 && !v.en2 ? "R7" : "R8", $sformatf("clk_en idle v%0d", i),
                  32'(exp_clk_en), 32'(v.en2));
        end

        // R6: reset command in autonomous mode clears count, keeps mode
        send(4'h4, 8'h00, 8'h00);
        check("R8", "start after clear", 32'(tx_msg), 32'({4'd7, 16'd0}));
        repeat (3) @(negedge clk);
        send(4'h2, 8'h00, 8'h00);
        check("R6", "reset-ok in auto", 32'(tx_msg), 32'({4'd4, 16'd0}));
        check("R6", "mode kept after reset", 32'(exp_clk_en), 32'd1);
        @(negedge clk);
        send(4'h6, 8'h00, 8'h00);
        check("R6", "count restarts after reset", 32'(tx_msg), 32'({4'd11, 16'd2}));
        @(negedge clk);
        send(4'h5, 8'h00, 8'h00);
        check("R8", "pause value", 32'(tx_msg), 32'({4'd9, 16'd4}));
        @(negedge clk);
        check("R8", "clk_en low after pause", 32'(exp_clk_en), 32'd0);

        // R11: nothing is taken while the response side is busy
        tx_ready = 1'b0;
        rx_msg   = {4'h1, 8'h55, 8'h99};
        rx_ready = 1'b1;
        #1;
        check("R11", "rx_next blocked", 32'(rx_next), 32'd0);
        check("R11", "exp_wen blocked", 32'(exp_wen), 32'd0);
        rx_msg = {4'h2, 8'h00, 8'h00};
        #1;
        check("R11", "exp_rst blocked", 32'(exp_rst), 32'd0);
        @(negedge clk);
        check("R11", "no response while busy", 32'(tx_next), 32'd0);
        rx_ready = 1'b0;
        tx_ready = 1'b1;
        @(negedge clk);
        send(4'h6, 8'h00, 8'h00);
        check("R11", "count untouched by blocked reset", 32'(tx_msg), 32'({4'd11, 16'd4}));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule